// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block stands in front of a scratchpad that is split into word-wide banks. It takes one memory operation from a group of lanes at a time. Each lane supplies a word address, an active bit, and, for a store, a data word. The low address bits select a bank and the remaining bits select a word inside that bank. Lanes that land in different banks are served in the same cycle. Lanes that name the same word share one bank access, so a broadcast read costs nothing extra. Lanes that land in one bank at different words are spread over successive cycles.

The arbiter holds the whole request while it works. It raises a one-cycle done pulse with the read data for every lane and the number of service cycles the request used. That count equals the largest number of distinct words asked of any single bank, not the number of lanes. The address generator and the thread scheduler sit outside this block.

Top module: `bank_conflict_arbiter`

## Requirements
- R1: The bank of a word address is its low log2(NBANK) bits, i.e. address modulo NBANK. The word inside the bank is the remaining upper bits. A word that is written is returned unchanged by a later read of the same address.
- R2: `req_ready` is high only while the arbiter is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Changes on the request inputs while a request is in progress have no effect on its result.
- R3: When every active lane maps to a different bank, the request takes one service cycle. This covers linear stride 1, any odd stride, and any one-to-one permutation of banks.
- R4: When all active lanes name the identical word, a read takes one service cycle and every active lane receives that word.
- R5: The service cycle count equals the largest number of distinct words requested from any single bank. For 16 lanes and 16 banks, stride 2 gives 2, stride 8 gives 8 and stride 16 gives 16.
- R6: Inside a conflicting bank, lanes that read the same word are served by one shared access, so they add no cycles.
- R7: When several active lanes write the same word in one request, the word afterwards holds the data of the highest-numbered of those lanes.
- R8: Inactive lanes (mask bit 0) are not counted for conflicts and return zero data. A request with no active lane still takes one service cycle and completes.
- R9: `done` is high for exactly one cycle per request. `rsp_data` and `rsp_cycles` are valid while `done` is high. For a store, every lane reads back zero.
- R10: With K service cycles, `done` is high in the (K+1)-th cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Arbiter idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mask | input | LANES | Active lanes |
| req_addr | input | LANES*AW | Word address of each lane, lane 0 in the low bits |
| req_wdata | input | LANES*DW | Store data of each lane, lane 0 in the low bits |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | LANES*DW | Load data of each lane, lane 0 in the low bits |
| rsp_cycles | output | CW | Service cycles the request used |

## Verification
The bench keeps the full 16-lane, 16-bank geometry, so every strided pattern hits its exact multiplicity: odd strides give 1, stride 2 gives 2, stride 8 gives 8 and stride 16 gives 16. Only the bank depth is reduced, to 64 words, which still leaves room for a 512-word preset pattern. That preset lets the bench check every read value without deep storage. With this geometry the bench reaches the worst case, where all lanes conflict, as well as broadcast, mixed shared-word groups, same-word write ordering and partial masks.

// File: rtl/lba_pkg.sv
package lba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_DONE  = 2'd2
    } lba_state_e;
endpackage

// File: rtl/lba_bank.sv
// One word-wide storage bank: one access per cycle, read is combinational.
module lba_bank #(
    parameter int WORDS = 256,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/lba_pick.sv
// Per bank: the lowest pending lane sets the word served this cycle; every
// pending lane naming that same word rides along on the same access.
module lba_pick #(
    parameter int LANES = 16,
    parameter int NBANK = 16,
    parameter int AW    = 12,
    localparam int BW   = $clog2(NBANK),
    localparam int IW   = AW - BW,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr,
    output logic [LANES-1:0]    grant,
    output logic [NBANK-1:0]    bank_en,
    output logic [NBANK*IW-1:0] bank_idx,
    output logic [NBANK*LW-1:0] bank_wlane
);
    logic [LANES-1:0] hit_m [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             found_c;
        logic [AW-1:0]    lead_c;
        logic [LANES-1:0] hit_c;
        logic [LW-1:0]    wl_c;

        always_comb begin
            found_c = 1'b0;
            lead_c  = '0;
            hit_c   = '0;
            wl_c    = '0;
            for (int l = 0; l < LANES; l++) begin
                if (!found_c && pend[l] && addr[l*AW +: BW] == BW'(b)) begin
                    found_c = 1'b1;
                    lead_c  = addr[l*AW +: AW];
                end
            end
            for (int l = 0; l < LANES; l++) begin
                if (found_c && pend[l] && addr[l*AW +: AW] == lead_c) begin
                    hit_c[l] = 1'b1;
                    wl_c     = LW'(l);
                end
            end
        end

        assign hit_m[b]               = hit_c;
        assign bank_en[b]             = found_c;
        assign bank_idx[b*IW +: IW]   = lead_c[AW-1:BW];
        assign bank_wlane[b*LW +: LW] = wl_c;
    end

    always_comb begin
        grant = '0;
        for (int b = 0; b < NBANK; b++) begin
            grant = grant | hit_m[b];
        end
    end
endmodule

// File: rtl/bank_conflict_arbiter.sv
module bank_conflict_arbiter
    import lba_pkg::*;
#(
    parameter int LANES      = 16,
    parameter int NBANK      = 16,
    parameter int BANK_WORDS = 256,
    parameter int DW         = 32,
    localparam int BW        = $clog2(NBANK),
    localparam int IW        = $clog2(BANK_WORDS),
    localparam int AW        = BW + IW,
    localparam int LW        = $clog2(LANES),
    localparam int CW        = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [LANES-1:0]    req_mask,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_wdata,
    output logic                done,
    output logic [LANES*DW-1:0] rsp_data,
    output logic [CW-1:0]       rsp_cycles
);
    typedef struct packed {
        lba_state_e          st;
        logic [LANES-1:0]    pend;
        logic                we;
        logic [LANES*AW-1:0] addr;
        logic [LANES*DW-1:0] wdata;
        logic [LANES*DW-1:0] rdata;
        logic [CW-1:0]       cnt;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [LANES-1:0]    grant;
    logic [NBANK-1:0]    bank_en;
    logic [NBANK*IW-1:0] bank_idx;
    logic [NBANK*LW-1:0] bank_wlane;
    logic [DW-1:0]       bank_rd [NBANK];

    lba_pick #(
        .LANES(LANES),
        .NBANK(NBANK),
        .AW   (AW)
    ) u_pick (
        .pend      (ctx_q.pend),
        .addr      (ctx_q.addr),
        .grant     (grant),
        .bank_en   (bank_en),
        .bank_idx  (bank_idx),
        .bank_wlane(bank_wlane)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_store
        logic [LW-1:0] wl;
        logic [DW-1:0] wd;
        logic          we;

        assign wl = bank_wlane[b*LW +: LW];
        assign wd = ctx_q.wdata[int'(wl)*DW +: DW];
        assign we = (ctx_q.st == ST_SERVE) && ctx_q.we && bank_en[b];

        lba_bank #(
            .WORDS(BANK_WORDS),
            .DW   (DW)
        ) u_bank (
            .clk  (clk),
            .wr_en(we),
            .idx  (bank_idx[b*IW +: IW]),
            .wdata(wd),
            .rdata(bank_rd[b])
        );
    end

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.st    = ST_SERVE;
                    ctx_d.pend  = req_mask;
                    ctx_d.we    = req_write;
                    ctx_d.addr  = req_addr;
                    ctx_d.wdata = req_wdata;
                    ctx_d.rdata = '0;
                    ctx_d.cnt   = '0;
                end
            end
            ST_SERVE: begin
                ctx_d.pend = ctx_q.pend & ~grant;
                ctx_d.cnt  = ctx_q.cnt + CW'(1);
                for (int l = 0; l < LANES; l++) begin
                    if (grant[l] && !ctx_q.we) begin
                        ctx_d.rdata[l*DW +: DW] = bank_rd[ctx_q.addr[l*AW +: BW]];
                    end
                end
                if ((ctx_q.pend & ~grant) == '0) begin
                    ctx_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready  = (ctx_q.st == ST_IDLE);
    assign done       = (ctx_q.st == ST_DONE);
    assign rsp_data   = ctx_q.rdata;
    assign rsp_cycles = ctx_q.cnt;
endmodule

// File: rtl/lba_checker.sv
module lba_checker #(
    parameter int LANES = 16,
    parameter int DW    = 32,
    parameter int CW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [LANES-1:0]    req_mask,
    input logic                done,
    input logic [LANES*DW-1:0] rsp_data,
    input logic [CW-1:0]       rsp_cycles
);
    logic [LANES-1:0] mask_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_seen <= '0;
        end else if (req_valid && req_ready) begin
            mask_seen <= req_mask;
        end
    end

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cycles_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_cycles >= CW'(1)) && (rsp_cycles <= CW'(LANES)));

    assert_cycles_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mask_seen != '0) |-> (32'(rsp_cycles) <= 32'($countones(mask_seen))));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !mask_seen[l]) |-> (rsp_data[l*DW +: DW] == '0));
    end
endmodule

bind bank_conflict_arbiter lba_checker #(
    .LANES(LANES),
    .DW   (DW),
    .CW   (CW)
) u_lba_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .done      (done),
    .rsp_data  (rsp_data),
    .rsp_cycles(rsp_cycles)
);

// File: tb/tb_bank_conflict_arbiter.sv
module tb_bank_conflict_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int NBANK = 16;
    localparam int BANK_WORDS = 64;
    localparam int DW = 32;
    localparam int AW = $clog2(NBANK) + $clog2(BANK_WORDS);
    localparam int CW = $clog2(LANES + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [LANES-1:0]    req_mask = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES*DW-1:0] req_wdata = '0;
    logic                done;
    logic [LANES*DW-1:0] rsp_data;
    logic [CW-1:0]       rsp_cycles;

    int n_chk = 0;
    int n_err = 0;

    logic [AW-1:0]    t_addr [LANES];
    logic [DW-1:0]    t_wd   [LANES];
    logic [LANES-1:0] t_mask;
    logic [DW-1:0]    got    [LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_conflict_arbiter #(
        .LANES(LANES), .NBANK(NBANK), .BANK_WORDS(BANK_WORDS), .DW(DW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mask(req_mask), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rsp_data(rsp_data),
        .rsp_cycles(rsp_cycles)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return 32'hC0DE_0000 ^ (32'(a) * 32'h0001_0003);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pack();
        for (int l = 0; l < LANES; l++) begin
            req_addr[l*AW +: AW]  = t_addr[l];
            req_wdata[l*DW +: DW] = t_wd[l];
        end
        req_mask = t_mask;
    endtask

    // Issues the staged request and checks service count and latency (R10).
    task automatic run_req(input logic wr, input int exp_cyc, input string req,
                           input bit scramble);
        int lat;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before offer", 32'(req_ready), 32'd1);
        req_write = wr;
        pack();
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (!scramble) req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 64) begin
            if (scramble) begin
                chk(req_ready == 1'b0, "R2", "ready while busy", 32'(req_ready), 32'd0);
                req_addr  = ~req_addr;
                req_wdata = ~req_wdata;
                req_write = ~wr;
            end
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        for (int l = 0; l < LANES; l++) got[l] = rsp_data[l*DW +: DW];
        chk(32'(rsp_cycles) == 32'(exp_cyc), req, "service cycles", 32'(rsp_cycles), 32'(exp_cyc));
        chk(lat == exp_cyc + 1, "R10", "done latency", 32'(lat), 32'(exp_cyc + 1));
        @(negedge clk);
        chk(done == 1'b0, "R9", "done single pulse", 32'(done), 32'd0);
    endtask

    task automatic stage_stride(input int base, input int s);
        t_mask = '1;
        for (int l = 0; l < LANES; l++) begin
            t_addr[l] = AW'(base + s * l);
            t_wd[l]   = pat(base + s * l);
        end
    endtask

    task automatic expect_reads(input string req);
        int bad;
        bad = -1;
        for (int l = 0; l < LANES; l++) begin
            if (t_mask[l] && got[l] !== pat(int'(t_addr[l])) && bad < 0) bad = l;
            if (!t_mask[l] && got[l] !== '0 && bad < 0) bad = l;
        end
        if (bad < 0) chk(1'b1, req, "lane data", 32'd0, 32'd0);
        else chk(1'b0, req, $sformatf("lane %0d data", bad), got[bad],
                 t_mask[bad] ? pat(int'(t_addr[bad])) : 32'd0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R2", "reset ready", 32'(req_ready), 32'd1);
        chk(done == 1'b0, "R9", "reset done", 32'(done), 32'd0);
        chk(rsp_cycles == '0, "R9", "reset count", 32'(rsp_cycles), 32'd0);
    endtask

    // R1: preset words 0..511 with pat(); stride-1 stores are conflict free (R3).
    task automatic t_fill();
        for (int k = 0; k < 32; k++) begin
            stage_stride(16 * k, 1);
            run_req(1'b1, 1, "R3", 1'b0);
            if (k == 0) begin
                chk(got[3] == '0, "R9", "store returns zero", got[3], 32'd0);
            end
        end
    endtask

    task automatic t_strides();
        stage_stride(5, 1);   run_req(1'b0, 1, "R3", 1'b0);  expect_reads("R1");
        stage_stride(2, 3);   run_req(1'b0, 1, "R3", 1'b0);  expect_reads("R3");
        stage_stride(9, 7);   run_req(1'b0, 1, "R3", 1'b0);  expect_reads("R3");
        stage_stride(0, 2);   run_req(1'b0, 2, "R5", 1'b0);  expect_reads("R5");
        stage_stride(1, 8);   run_req(1'b0, 8, "R5", 1'b0);  expect_reads("R5");
        stage_stride(3, 16);  run_req(1'b0, 16, "R5", 1'b0); expect_reads("R5");
    endtask

    task automatic t_permute();
        t_mask = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'(((l * 5) % 16) + 32);
        run_req(1'b0, 1, "R3", 1'b0);
        expect_reads("R3");
    endtask

    task automatic t_broadcast();
        t_mask = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'(37);
        run_req(1'b0, 1, "R4", 1'b0);
        expect_reads("R4");
    endtask

    // R6: two words in bank 4, eight lanes each -> two cycles.
    task automatic t_shared_group();
        t_mask = '1;
        for (int l = 0; l < LANES; l++) t_addr[l] = AW'((l < 8) ? 4 : 20);
        run_req(1'b0, 2, "R6", 1'b0);
        expect_reads("R6");
    endtask

    // R7: all lanes store lane number to word 600; highest active lane wins.
    task automatic t_write_order();
        t_mask = '1;
        for (int l = 0; l < LANES; l++) begin
            t_addr[l] = AW'(600);
            t_wd[l]   = 32'(l) + 32'h100;
        end
        run_req(1'b1, 1, "R7", 1'b0);
        run_req(1'b0, 1, "R7", 1'b0);
        chk(got[0] == 32'h10F, "R7", "all lanes win lane 15", got[0], 32'h10F);
        t_mask = 16'h7FFF;
        run_req(1'b1, 1, "R7", 1'b0);
        t_mask = 16'h0001;
        run_req(1'b0, 1, "R7", 1'b0);
        chk(got[0] == 32'h10E, "R7", "lane 15 masked, lane 14 wins", got[0], 32'h10E);
    endtask

    task automatic t_masks();
        stage_stride(3, 16);
        t_mask = 16'h0003;
        run_req(1'b0, 2, "R8", 1'b0);
        expect_reads("R8");
        t_mask = 16'h0000;
        run_req(1'b0, 1, "R8", 1'b0);
        expect_reads("R8");
        // Inactive lanes of conflicting addresses do not add cycles.
        stage_stride(0, 16);
        t_mask = 16'h8001;
        for (int l = 1; l < 15; l++) t_addr[l] = AW'(16 * l + 5);
        run_req(1'b0, 2, "R8", 1'b0);
        expect_reads("R8");
    endtask

    // R2: inputs scrambled and valid held during service do not alter result.
    task automatic t_busy_ignore();
        stage_stride(6, 16);
        run_req(1'b0, 16, "R2", 1'b1);
        expect_reads("R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_strides();
        t_permute();
        t_broadcast();
        t_shared_group();
        t_write_order();
        t_masks();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule